// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block turns the input oscillator clock into an instruction cycle of four input clocks. Each input clock carries exactly one of four phase enables, Q1 to Q4, in a fixed rotation. It also produces a clock-out at one quarter of the input rate. The block paces a two-stage pipeline: the fetch address moves on as Q1 begins, and the word read from program memory is captured into the instruction register at the close of Q4.

During the next instruction cycle the captured word is decoded and executed, while the word at the following address is fetched. Fetch addresses therefore step by a fixed increment, 2 by default, once per instruction cycle. A flush input, sampled at the close of Q4, captures a no-op in place of the fetched word. The execution datapath raises it for a taken branch, so that the word fetched behind the branch never executes. The oscillator and the execution datapath sit outside this block.

Top module: `quad_phase_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the state returns to Q1; phase bit 0 stands for Q1, bit 1 for Q2, bit 2 for Q3 and bit 3 for Q4, so the first cycle after reset shows phase = 4'b0001.
- R2: Exactly one phase bit is high in every clock cycle, and the phases rotate Q1, Q2, Q3, Q4, Q1 with one phase per clock.
- R3: clk_out is high during Q1 and Q2 and low during Q3 and Q4.
- R4: fetch_addr equals RESET_PC after reset and advances by PC_STEP at the edge that closes each Q4, so the new address shows in Q1; pc_inc is high in every Q1 except the first one after reset.
- R5: ir_load is high during Q4 only; at the edge that closes Q4, ir takes fetch_word and exec_addr takes fetch_addr, and both then hold for the next four cycles.
- R6: If flush is high at the edge that closes Q4, ir takes the no-op word NOP_WORD (default 0) instead of fetch_word, while exec_addr still advances.
- R7: flush sampled at an edge that closes Q1, Q2 or Q3 has no effect on ir.
- R8: After reset, ir holds NOP_WORD, exec_addr holds RESET_PC and pc_inc is low.
- R9: fetch_addr wraps modulo 2^PC_W, so an advance from the top address range continues from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Capture a no-op instead of the fetched word at the close of Q4 |
| fetch_word | input | INSN_W | Program memory word read at fetch_addr |
| phase | output | 4 | One-hot phase enables, bit 0 = Q1 to bit 3 = Q4 |
| clk_out | output | 1 | Clock-out at one quarter of the input rate |
| pc_inc | output | 1 | High in Q1 when the fetch address has just advanced |
| ir_load | output | 1 | High in Q4; the instruction register loads at its close |
| fetch_addr | output | PC_W | Address of the word being fetched |
| ir | output | INSN_W | Instruction register, the word in execution |
| exec_addr | output | PC_W | Address of the word held in ir |

## Verification
The phase enables, clk_out and pc_inc are all due in the very cycle that follows the edge that moves the phase register. ir and exec_addr are due in the Q1 that follows the edge closing Q4, and fetch_addr moves at that same edge. The bench counts cycles since reset, drives flush on the falling edge and samples every output on the next falling edge, so each expectation is taken one full register stage after the stimulus edge. Flush is applied both in the Q4 window and outside it, and the reset address sits near the top of the range so that the wrap of fetch_addr happens within the run.

// File: rtl/qps_pkg.sv
// Package: shared types and constants for the four-phase sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package qps_pkg;
    localparam int NUM_PHASES = 4;
    localparam int PH_W       = $clog2(NUM_PHASES);

    typedef enum logic [PH_W-1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;
endpackage

// File: rtl/qps_phase_gen.sv
// Module: qps_phase_gen
// Divides the input clock into four one-hot phase enables and a clock-out
// at one quarter rate. Assumes a synchronous active-low reset that parks
// the sequence at Q1; all outputs are registered.
module qps_phase_gen
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic                  clk_out_o
);
    phase_e cur_q;
    phase_e nxt;

    // Next phase in the fixed rotation.
    always_comb nxt = phase_e'(cur_q + 1'b1);

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= PH_Q1;
        else        cur_q <= nxt;
    end

    // Registered one-hot decode, one flop per phase.
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_ph
        always_ff @(posedge clk) begin
            if (!rst_n) phase_o[i] <= (i == 0);
            else        phase_o[i] <= (nxt == phase_e'(i));
        end
    end

    // Clock-out: high for the first half of the instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_out_o <= 1'b1;
        else        clk_out_o <= (nxt == PH_Q1) || (nxt == PH_Q2);
    end

    p_reset_q1_r1: assert property (@(posedge clk)
        !rst_n |=> phase_o == 4'b0001);
    p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o) == 1);
    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[3] |=> phase_o[0]);
    p_clkout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out_o == (phase_o[0] || phase_o[1]));
endmodule

// File: rtl/qps_pc.sv
// Module: qps_pc
// Fetch address counter. Advances by PC_STEP at the edge that closes Q4
// so the new address is visible in Q1; flags that Q1 with pc_inc_o.
// Assumes enter_q1_i is the Q4 enable and at_q1_i the Q1 enable.
module qps_pc #(
    parameter int          PC_W     = 21,
    parameter int          PC_STEP  = 2,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_q1_i,
    input  logic            at_q1_i,
    output logic [PC_W-1:0] fetch_addr_o,
    output logic            pc_inc_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    logic started_q;

    // Address counter, wraps modulo 2^PC_W.
    always_ff @(posedge clk) begin
        if (!rst_n)          fetch_addr_o <= RESET_PC;
        else if (enter_q1_i) fetch_addr_o <= fetch_addr_o + STEP;
    end

    // Marks that at least one instruction cycle has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)          started_q <= 1'b0;
        else if (enter_q1_i) started_q <= 1'b1;
    end

    // Increment strobe in each Q1 that follows an advance.
    always_comb pc_inc_o = at_q1_i && started_q;

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o |-> fetch_addr_o == $past(fetch_addr_o) + STEP);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !enter_q1_i |=> $stable(fetch_addr_o));
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !pc_inc_o && fetch_addr_o == RESET_PC);
endmodule

// File: rtl/qps_ir.sv
// Module: qps_ir
// Instruction register and its address. Loads at the edge that closes Q4,
// substituting NOP_WORD when flush_i is high at that edge. Assumes ld_i is
// the Q4 enable; flush_i in other phases is ignored.
module qps_ir #(
    parameter int                PC_W     = 21,
    parameter int                INSN_W   = 16,
    parameter logic [INSN_W-1:0] NOP_WORD = '0,
    parameter logic [PC_W-1:0]   RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              flush_i,
    input  logic [INSN_W-1:0] word_i,
    input  logic [PC_W-1:0]   addr_i,
    output logic [INSN_W-1:0] ir_o,
    output logic [PC_W-1:0]   exec_addr_o
);
    // Instruction word capture with flush substitution.
    always_ff @(posedge clk) begin
        if (!rst_n)    ir_o <= NOP_WORD;
        else if (ld_i) ir_o <= flush_i ? NOP_WORD : word_i;
    end

    // Address of the captured word.
    always_ff @(posedge clk) begin
        if (!rst_n)    exec_addr_o <= RESET_PC;
        else if (ld_i) exec_addr_o <= addr_i;
    end

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i && flush_i |=> ir_o == NOP_WORD);
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i && !flush_i |=> ir_o == $past(word_i));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(ir_o) && $stable(exec_addr_o));
endmodule

// File: rtl/quad_phase_seq.sv
// Module: quad_phase_seq (top)
// Four-phase instruction cycle sequencer for a two-stage fetch/execute
// pipeline. Assumes program memory returns fetch_word combinationally
// for fetch_addr within the Q1..Q4 window, and that flush comes from the
// execution datapath in the same clock domain.
module quad_phase_seq #(
    parameter int                PC_W     = 21,
    parameter int                INSN_W   = 16,
    parameter int                PC_STEP  = 2,
    parameter logic [INSN_W-1:0] NOP_WORD = '0,
    parameter logic [PC_W-1:0]   RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [INSN_W-1:0] fetch_word,
    output logic [3:0]        phase,
    output logic              clk_out,
    output logic              pc_inc,
    output logic              ir_load,
    output logic [PC_W-1:0]   fetch_addr,
    output logic [INSN_W-1:0] ir,
    output logic [PC_W-1:0]   exec_addr
);
    import qps_pkg::*;

    logic [NUM_PHASES-1:0] ph;

    qps_phase_gen u_ph (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (ph),
        .clk_out_o (clk_out)
    );

    qps_pc #(.PC_W(PC_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_q1_i   (ph[PH_Q4]),
        .at_q1_i      (ph[PH_Q1]),
        .fetch_addr_o (fetch_addr),
        .pc_inc_o     (pc_inc)
    );

    qps_ir #(.PC_W(PC_W), .INSN_W(INSN_W), .NOP_WORD(NOP_WORD),
             .RESET_PC(RESET_PC)) u_ir (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_i        (ph[PH_Q4]),
        .flush_i     (flush),
        .word_i      (fetch_word),
        .addr_i      (fetch_addr),
        .ir_o        (ir),
        .exec_addr_o (exec_addr)
    );

    // Phase and latch strobes to the pins.
    always_comb begin
        phase   = ph;
        ir_load = ph[PH_Q4];
    end

    p_exec_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> exec_addr + PC_W'(PC_STEP) == fetch_addr);
endmodule

// File: tb/sim_quad_phase_seq.sv
`timescale 1ns/1ps
module sim_quad_phase_seq;
    localparam int          PC_W   = 21;
    localparam int          INSN_W = 16;
    localparam int          STEP   = 2;
    localparam logic [15:0] NOP    = 16'h0000;
    localparam logic [20:0] RPC    = 21'h1FFFF8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic [INSN_W-1:0] fetch_word;
    logic [3:0]        phase;
    logic              clk_out, pc_inc, ir_load;
    logic [PC_W-1:0]   fetch_addr, exec_addr;
    logic [INSN_W-1:0] ir;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit done = 0;
    logic [INSN_W-1:0] exp_ir;
    logic [PC_W-1:0]   exp_exec;

    always #2 clk = ~clk;

    quad_phase_seq #(.PC_W(PC_W), .INSN_W(INSN_W), .PC_STEP(STEP),
                     .NOP_WORD(NOP), .RESET_PC(RPC)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_word(fetch_word),
        .phase(phase), .clk_out(clk_out), .pc_inc(pc_inc), .ir_load(ir_load),
        .fetch_addr(fetch_addr), .ir(ir), .exec_addr(exec_addr)
    );

    // Program memory model: nonzero word derived from the address.
    function automatic logic [15:0] word_at(input logic [20:0] a);
        return 16'h8000 | {1'b0, a[14:0] ^ 15'h1234};
    endfunction
    assign fetch_word = word_at(fetch_addr);

    function automatic logic [20:0] exp_fetch(input int n);
        return RPC + 21'(STEP * (n / 4));
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model for cycle k.
    task automatic check_all();
        int p = k % 4;
        chk(32'(phase), 32'(1 << p), "R2", "phase");
        chk(32'(clk_out), 32'(p < 2), "R3", "clk_out");
        chk(32'(pc_inc), 32'(p == 0 && k >= 4), "R4", "pc_inc");
        chk(32'(ir_load), 32'(p == 3), "R5", "ir_load");
        if (exp_fetch(k) < RPC) chk(32'(fetch_addr), 32'(exp_fetch(k)), "R9", "fetch_addr wrap");
        else                    chk(32'(fetch_addr), 32'(exp_fetch(k)), "R4", "fetch_addr");
        chk(32'(ir), 32'(exp_ir), "R5/R6/R7", "ir");
        chk(32'(exec_addr), 32'(exp_exec), "R5", "exec_addr");
    endtask

    // One clock with flush level fl; update model at the edge, check after.
    task automatic tick(input logic fl);
        flush = fl;
        @(posedge clk);
        if (k % 4 == 3) begin
            exp_ir   = fl ? NOP : word_at(exp_fetch(k));
            exp_exec = exp_fetch(k);
        end
        k++;
        @(negedge clk);
        flush = 1'b0;
        check_all();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        k = 0; exp_ir = NOP; exp_exec = RPC;
        chk(32'(phase), 32'h1, "R1", "reset phase Q1");
        chk(32'(ir), 32'(NOP), "R8", "reset ir");
        chk(32'(exec_addr), 32'(RPC), "R8", "reset exec_addr");
        chk(32'(pc_inc), 32'h0, "R8", "reset pc_inc");
        chk(32'(fetch_addr), 32'(RPC), "R4", "reset fetch_addr");
    endtask

    // Plain run: rotation, clock-out, fetch advance and wrap (R9).
    task automatic t_run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    // Flush in the Q4 window: next cycle executes a no-op (R6).
    task automatic t_flush_q4();
        while (k % 4 != 3) tick(1'b0);
        tick(1'b1);
        chk(32'(ir), 32'(NOP), "R6", "ir after flush");
        t_run(4);
    endtask

    // Flush in Q1..Q3 only: ignored (R7).
    task automatic t_flush_early();
        while (k % 4 != 0) tick(1'b0);
        tick(1'b1); tick(1'b1); tick(1'b1);
        tick(1'b0);
        chk(32'(ir), 32'(word_at(exec_addr)), "R7", "ir ignores early flush");
    endtask

    initial begin
        t_reset();
        t_run(24);
        t_flush_q4();
        t_flush_early();
        t_reset();
        t_run(9);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule